// File: doc/BRIEF.md
# Four-Way Set-Associative Read Cache

This block is a read-only cache controller that sits between a CPU load port and an external memory read interface. It holds 256 sets of four ways each, and every line is 16 bytes wide, stored as four 32-bit words. The set is chosen from the untranslated (virtual) address. The line tag is compared against a physical page tag that an external translation stage delivers in the same cycle as the request. Because the set index sits entirely inside the page offset, a line can be located before translation completes and then confirmed once the physical tag arrives.

On a hit, the addressed word goes back to the CPU in the cycle the request is accepted, and the set's recency state is refreshed. On a miss, the controller requests the whole line from memory and receives four beats, lowest word first. It hands the wanted word to the CPU in the very cycle that word arrives from memory, while the rest of the line is still streaming into the arrays. When the last beat lands, the line is marked valid and its updated flag is cleared. New requests are held off by a low ready signal until the refill is over.

Top module: `sa4_read_cache`

## Requirements
- R1: After reset, `req_ready_o` is 1, `rsp_valid_o` and `mem_req_valid_o` are 0, and every line is invalid, so the first read of any set misses.
- R2: The set is `req_vaddr_i[11:4]`. A hit needs a valid way in that set whose stored tag equals `req_ptag_i` (physical address bits 31:12). The same tag in another set, or another tag in the same set, misses.
- R3: On a hit, `rsp_valid_o` and `rsp_hit_o` are 1 in the acceptance cycle, and `rsp_data_o` is the word chosen by `req_vaddr_i[3:2]`.
- R4: On a miss, `mem_req_valid_o` rises in the cycle after acceptance, with `mem_req_addr_o = {req_ptag_i, req_vaddr_i[11:4], 4'b0000}`. Both stay unchanged until a cycle with `mem_req_ready_i` high.
- R5: After the memory request handshake, the line arrives as four `mem_rsp_valid_i` beats carrying words 0, 1, 2, 3 in order. Beats may have gaps between them. In the cycle of the beat whose index equals `req_vaddr_i[3:2]`, exactly one response is given: `rsp_valid_o`=1, `rsp_hit_o`=0, and `rsp_data_o` equal to the beat data.
- R6: `req_ready_o` is 0 from the cycle after a miss is accepted until the last beat. It is 1 again in the cycle after the last beat.
- R7: Once a refill completes, the line is valid, its updated flag is 0, and all four of its words hit with the refilled data.
- R8: The way chosen for a refill is the lowest-numbered invalid way of the set, when one exists.
- R9: When all four ways of a set are valid, the refill replaces the least recently used way. Both hits and refills count as uses, and after reset way 0 is the least recent.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | CPU read request |
| req_ready_o | output | 1 | Request accepted when high with req_valid_i |
| req_vaddr_i | input | 10 | Virtual address bits 11:2 (set and word) |
| req_ptag_i | input | 20 | Physical address bits 31:12 from translation |
| rsp_valid_o | output | 1 | Read data valid |
| rsp_hit_o | output | 1 | Response came from a hit (0: forwarded refill beat) |
| rsp_data_o | output | 32 | Read data |
| mem_req_valid_o | output | 1 | Line read request to memory |
| mem_req_ready_i | input | 1 | Memory accepts the line request |
| mem_req_addr_o | output | 32 | Line-aligned physical address |
| mem_rsp_valid_i | input | 1 | Refill beat valid |
| mem_rsp_data_i | input | 32 | Refill beat data |

## Verification
A hit is due in the acceptance cycle itself, so the bench drives inputs shortly after a rising edge and samples results at the falling edge of that same cycle. A miss response is due in the cycle of the matching refill beat, and the memory model drives each beat on the same schedule, so the forwarded word is compared in the cycle the beat is presented. The line request is checked in the first cycle after acceptance and in every cycle of its hold. The ready flag is checked during each refill cycle and in the first cycle after the last beat. Replacement order is checked through the hit-or-miss outcome of later reads and the line addresses those reads send to memory.

// File: rtl/sa4_cache_pkg.sv
package sa4_cache_pkg;
  localparam int unsigned NUM_WAYS = 4;
  localparam int unsigned WAY_W    = $clog2(NUM_WAYS);
  localparam int unsigned LRU_W    = NUM_WAYS * (NUM_WAYS - 1) / 2;

  typedef logic [WAY_W-1:0] way_t;
  typedef logic [LRU_W-1:0] lru_t;

  typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_FILL} fill_state_e;

  // pair bit k for (i<j): 1 = way i used more recently than way j
  function automatic lru_t lru_touch(lru_t cur, way_t w);
    lru_t nxt;
    int unsigned k;
    nxt = cur;
    k = 0;
    for (int unsigned i = 0; i < NUM_WAYS; i++) begin
      for (int unsigned j = i + 1; j < NUM_WAYS; j++) begin
        if (way_t'(i) == w) nxt[k] = 1'b1;
        else if (way_t'(j) == w) nxt[k] = 1'b0;
        k++;
      end
    end
    return nxt;
  endfunction

  function automatic way_t lru_oldest(lru_t cur);
    way_t pick;
    logic found;
    pick  = '0;
    found = 1'b0;
    for (int unsigned w = 0; w < NUM_WAYS; w++) begin
      logic older;
      int unsigned k;
      older = 1'b1;
      k = 0;
      for (int unsigned i = 0; i < NUM_WAYS; i++) begin
        for (int unsigned j = i + 1; j < NUM_WAYS; j++) begin
          if (i == w && cur[k]) older = 1'b0;
          if (j == w && !cur[k]) older = 1'b0;
          k++;
        end
      end
      if (older && !found) begin
        pick  = way_t'(w);
        found = 1'b1;
      end
    end
    return pick;
  endfunction
endpackage

// File: rtl/cache_tag_store.sv
module cache_tag_store
  import sa4_cache_pkg::*;
#(
  parameter int unsigned SETS  = 256,
  parameter int unsigned TAG_W = 20,
  localparam int unsigned IDX_W = $clog2(SETS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] lk_idx_i,
  input  logic [TAG_W-1:0] lk_tag_i,
  output logic             hit_o,
  output way_t             hit_way_o,
  output logic             hit_u_o,
  output way_t             victim_way_o,
  input  logic             touch_en_i,
  input  logic [IDX_W-1:0] touch_idx_i,
  input  way_t             touch_way_i,
  input  logic             fill_en_i,
  input  logic [IDX_W-1:0] fill_idx_i,
  input  way_t             fill_way_i,
  input  logic [TAG_W-1:0] fill_tag_i
);
  logic [NUM_WAYS-1:0][SETS-1:0] valid_q;
  logic [NUM_WAYS-1:0][SETS-1:0] upd_q;
  lru_t [SETS-1:0]               lru_q;
  logic [NUM_WAYS-1:0]           hit_vec, inv_vec, upd_vec;
  way_t                          inv_way;

  for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
    logic [TAG_W-1:0] tag_mem [SETS];
    always_ff @(posedge clk_i) begin
      if (fill_en_i && fill_way_i == way_t'(w)) tag_mem[fill_idx_i] <= fill_tag_i;
    end
    assign hit_vec[w] = valid_q[w][lk_idx_i] && (tag_mem[lk_idx_i] == lk_tag_i);
    assign inv_vec[w] = !valid_q[w][lk_idx_i];
    assign upd_vec[w] = upd_q[w][lk_idx_i];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      upd_q   <= '0;
      lru_q   <= '0;
    end else begin
      if (fill_en_i) begin
        valid_q[fill_way_i][fill_idx_i] <= 1'b1;
        upd_q[fill_way_i][fill_idx_i]   <= 1'b0;
      end
      if (touch_en_i) lru_q[touch_idx_i] <= lru_touch(lru_q[touch_idx_i], touch_way_i);
    end
  end

  always_comb begin
    hit_way_o = '0;
    inv_way   = '0;
    for (int w = NUM_WAYS - 1; w >= 0; w--) begin
      if (hit_vec[w]) hit_way_o = way_t'(w);
      if (inv_vec[w]) inv_way   = way_t'(w);
    end
  end

  assign hit_o        = |hit_vec;
  assign hit_u_o      = upd_vec[hit_way_o];
  assign victim_way_o = (|inv_vec) ? inv_way : lru_oldest(lru_q[lk_idx_i]);
endmodule

// File: rtl/cache_data_store.sv
module cache_data_store
  import sa4_cache_pkg::*;
#(
  parameter int unsigned SETS   = 256,
  parameter int unsigned WORDS  = 4,
  parameter int unsigned DATA_W = 32,
  localparam int unsigned LOC_W = $clog2(SETS) + $clog2(WORDS)
) (
  input  logic              clk_i,
  input  logic              wr_en_i,
  input  way_t              wr_way_i,
  input  logic [LOC_W-1:0]  wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  way_t              rd_way_i,
  input  logic [LOC_W-1:0]  rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o
);
  logic [NUM_WAYS-1:0][DATA_W-1:0] rd_vec;

  for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
    logic [DATA_W-1:0] mem [SETS*WORDS];
    always_ff @(posedge clk_i) begin
      if (wr_en_i && wr_way_i == way_t'(w)) mem[wr_addr_i] <= wr_data_i;
    end
    assign rd_vec[w] = mem[rd_addr_i];
  end

  assign rd_data_o = rd_vec[rd_way_i];
endmodule

// File: rtl/cache_refill_ctrl.sv
module cache_refill_ctrl
  import sa4_cache_pkg::*;
#(
  parameter int unsigned IDX_W  = 8,
  parameter int unsigned OFF_W  = 2,
  parameter int unsigned TAG_W  = 20,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 32
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   req_valid_i,
  output logic                   req_ready_o,
  input  logic [IDX_W-1:0]       req_idx_i,
  input  logic [OFF_W-1:0]       req_word_i,
  input  logic [TAG_W-1:0]       req_tag_i,
  input  logic                   hit_i,
  input  way_t                   hit_way_i,
  input  way_t                   victim_way_i,
  input  logic [DATA_W-1:0]      hit_data_i,
  output logic                   rsp_valid_o,
  output logic                   rsp_hit_o,
  output logic [DATA_W-1:0]      rsp_data_o,
  output logic                   mem_req_valid_o,
  input  logic                   mem_req_ready_i,
  output logic [ADDR_W-1:0]      mem_req_addr_o,
  input  logic                   mem_rsp_valid_i,
  input  logic [DATA_W-1:0]      mem_rsp_data_i,
  output logic                   touch_en_o,
  output logic [IDX_W-1:0]       touch_idx_o,
  output way_t                   touch_way_o,
  output logic                   fill_en_o,
  output logic [IDX_W-1:0]       fill_idx_o,
  output way_t                   fill_way_o,
  output logic [TAG_W-1:0]       fill_tag_o,
  output logic                   wr_en_o,
  output logic [IDX_W+OFF_W-1:0] wr_addr_o
);
  fill_state_e      state_q;
  logic [IDX_W-1:0] idx_q;
  logic [OFF_W-1:0] word_q, beat_q;
  logic [TAG_W-1:0] tag_q;
  way_t             way_q;
  logic             idle, accept, hit_take, beat_fire, last_beat;

  assign idle      = (state_q == ST_IDLE);
  assign accept    = idle && req_valid_i;
  assign hit_take  = accept && hit_i;
  assign beat_fire = (state_q == ST_FILL) && mem_rsp_valid_i;
  assign last_beat = (beat_q == '1);

  assign req_ready_o     = idle;
  assign rsp_hit_o       = hit_take;
  assign rsp_valid_o     = hit_take || (beat_fire && beat_q == word_q);
  assign rsp_data_o      = hit_take ? hit_data_i : mem_rsp_data_i;
  assign mem_req_valid_o = (state_q == ST_REQ);
  assign mem_req_addr_o  = {tag_q, idx_q, {(OFF_W + 2){1'b0}}};

  assign touch_en_o  = hit_take || (beat_fire && last_beat);
  assign touch_idx_o = idle ? req_idx_i : idx_q;
  assign touch_way_o = idle ? hit_way_i : way_q;
  assign fill_en_o   = beat_fire && last_beat;
  assign fill_idx_o  = idx_q;
  assign fill_way_o  = way_q;
  assign fill_tag_o  = tag_q;
  assign wr_en_o     = beat_fire;
  assign wr_addr_o   = {idx_q, beat_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      word_q  <= '0;
      tag_q   <= '0;
      way_q   <= '0;
      beat_q  <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (accept && !hit_i) begin
          state_q <= ST_REQ;
          idx_q   <= req_idx_i;
          word_q  <= req_word_i;
          tag_q   <= req_tag_i;
          way_q   <= victim_way_i;
        end
        ST_REQ: if (mem_req_ready_i) begin
          state_q <= ST_FILL;
          beat_q  <= '0;
        end
        ST_FILL: if (mem_rsp_valid_i) begin
          beat_q <= beat_q + 1'b1;
          if (last_beat) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sa4_read_cache.sv
module sa4_read_cache
  import sa4_cache_pkg::*;
#(
  parameter int unsigned SETS   = 256,
  parameter int unsigned WORDS  = 4,
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32,
  localparam int unsigned IDX_W = $clog2(SETS),
  localparam int unsigned OFF_W = $clog2(WORDS),
  localparam int unsigned TAG_W = ADDR_W - IDX_W - OFF_W - 2,
  localparam int unsigned VA_HI = IDX_W + OFF_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [VA_HI:2]    req_vaddr_i,
  input  logic [TAG_W-1:0]  req_ptag_i,
  output logic              rsp_valid_o,
  output logic              rsp_hit_o,
  output logic [DATA_W-1:0] rsp_data_o,
  output logic              mem_req_valid_o,
  input  logic              mem_req_ready_i,
  output logic [ADDR_W-1:0] mem_req_addr_o,
  input  logic              mem_rsp_valid_i,
  input  logic [DATA_W-1:0] mem_rsp_data_i
);
  logic [IDX_W-1:0]       req_idx;
  logic [OFF_W-1:0]       req_word;
  logic                   hit, hit_u;
  way_t                   hit_way, victim_way;
  logic [DATA_W-1:0]      hit_data;
  logic                   touch_en, fill_en, wr_en;
  logic [IDX_W-1:0]       touch_idx, fill_idx;
  way_t                   touch_way, fill_way;
  logic [TAG_W-1:0]       fill_tag;
  logic [IDX_W+OFF_W-1:0] wr_addr;

  assign req_idx  = req_vaddr_i[VA_HI:OFF_W+2];
  assign req_word = req_vaddr_i[OFF_W+1:2];

  cache_tag_store #(.SETS(SETS), .TAG_W(TAG_W)) u_tags (
    .clk_i, .rst_ni,
    .lk_idx_i(req_idx), .lk_tag_i(req_ptag_i),
    .hit_o(hit), .hit_way_o(hit_way), .hit_u_o(hit_u), .victim_way_o(victim_way),
    .touch_en_i(touch_en), .touch_idx_i(touch_idx), .touch_way_i(touch_way),
    .fill_en_i(fill_en), .fill_idx_i(fill_idx), .fill_way_i(fill_way), .fill_tag_i(fill_tag)
  );

  cache_data_store #(.SETS(SETS), .WORDS(WORDS), .DATA_W(DATA_W)) u_data (
    .clk_i,
    .wr_en_i(wr_en), .wr_way_i(fill_way), .wr_addr_i(wr_addr), .wr_data_i(mem_rsp_data_i),
    .rd_way_i(hit_way), .rd_addr_i({req_idx, req_word}), .rd_data_o(hit_data)
  );

  cache_refill_ctrl #(
    .IDX_W(IDX_W), .OFF_W(OFF_W), .TAG_W(TAG_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
  ) u_ctrl (
    .clk_i, .rst_ni,
    .req_valid_i, .req_ready_o,
    .req_idx_i(req_idx), .req_word_i(req_word), .req_tag_i(req_ptag_i),
    .hit_i(hit), .hit_way_i(hit_way), .victim_way_i(victim_way), .hit_data_i(hit_data),
    .rsp_valid_o, .rsp_hit_o, .rsp_data_o,
    .mem_req_valid_o, .mem_req_ready_i, .mem_req_addr_o,
    .mem_rsp_valid_i, .mem_rsp_data_i,
    .touch_en_o(touch_en), .touch_idx_o(touch_idx), .touch_way_o(touch_way),
    .fill_en_o(fill_en), .fill_idx_o(fill_idx), .fill_way_o(fill_way), .fill_tag_o(fill_tag),
    .wr_en_o(wr_en), .wr_addr_o(wr_addr)
  );
endmodule

// File: rtl/sa4_read_cache_chk.sv
module sa4_read_cache_chk #(
  parameter int unsigned WORDS  = 4,
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic              req_ready_o,
  input logic              rsp_valid_o,
  input logic              rsp_hit_o,
  input logic [DATA_W-1:0] rsp_data_o,
  input logic              mem_req_valid_o,
  input logic              mem_req_ready_i,
  input logic [ADDR_W-1:0] mem_req_addr_o,
  input logic              mem_rsp_valid_i,
  input logic [DATA_W-1:0] mem_rsp_data_i,
  input logic              hit_u
);
  localparam int unsigned CNT_W = $clog2(WORDS);

  logic             in_fill_q;
  logic [CNT_W-1:0] beat_cnt_q;
  logic [1:0]       fwd_cnt_q;
  logic             miss_rsp;

  assign miss_rsp = rsp_valid_o && !rsp_hit_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_fill_q  <= 1'b0;
      beat_cnt_q <= '0;
      fwd_cnt_q  <= '0;
    end else if (mem_req_valid_o && mem_req_ready_i) begin
      in_fill_q  <= 1'b1;
      beat_cnt_q <= '0;
      fwd_cnt_q  <= '0;
    end else if (in_fill_q && mem_rsp_valid_i) begin
      beat_cnt_q <= beat_cnt_q + 1'b1;
      if (miss_rsp) fwd_cnt_q <= fwd_cnt_q + 1'b1;
      if (beat_cnt_q == CNT_W'(WORDS - 1)) in_fill_q <= 1'b0;
    end
  end

  a_r3_hit_in_accept_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_hit_o) |-> (req_valid_i && req_ready_o));

  a_r4_line_req_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_valid_o && !mem_req_ready_i) |=> (mem_req_valid_o && $stable(mem_req_addr_o)));

  a_r5_forward_on_beat: assert property (@(posedge clk_i) disable iff (!rst_ni)
    miss_rsp |-> (in_fill_q && mem_rsp_valid_i && rsp_data_o == mem_rsp_data_i));

  a_r5_one_forward_per_fill: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_fill_q && mem_rsp_valid_i && beat_cnt_q == CNT_W'(WORDS - 1))
      |-> (3'(fwd_cnt_q) + 3'(miss_rsp)) == 3'd1);

  a_r6_stall_during_refill: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_valid_o || in_fill_q) |-> !req_ready_o);

  a_r6_ready_after_last_beat: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_fill_q && mem_rsp_valid_i && beat_cnt_q == CNT_W'(WORDS - 1)) |=> req_ready_o);

  a_r7_hit_line_not_updated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_hit_o |-> !hit_u);
endmodule

bind sa4_read_cache sa4_read_cache_chk #(.WORDS(WORDS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni),
  .req_valid_i(req_valid_i), .req_ready_o(req_ready_o),
  .rsp_valid_o(rsp_valid_o), .rsp_hit_o(rsp_hit_o), .rsp_data_o(rsp_data_o),
  .mem_req_valid_o(mem_req_valid_o), .mem_req_ready_i(mem_req_ready_i),
  .mem_req_addr_o(mem_req_addr_o),
  .mem_rsp_valid_i(mem_rsp_valid_i), .mem_rsp_data_i(mem_rsp_data_i),
  .hit_u(hit_u)
);

// File: tb/sa4_read_cache_bench.sv
`timescale 1ns/1ps
module sa4_read_cache_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [11:2] req_vaddr = '0;
  logic [19:0] req_ptag = '0;
  logic        rsp_valid, rsp_hit;
  logic [31:0] rsp_data;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b0;
  logic [31:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;

  int checks = 0;
  int failures = 0;
  int req_lat = 0;
  int beat_gap = 0;

  logic [31:0] exp_data_q[$];
  bit          exp_hit_q[$];
  string       exp_req_q[$];
  logic [31:0] exp_line_q[$];

  always #10 clk = ~clk;

  sa4_read_cache u_sa4_read_cache (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_vaddr_i(req_vaddr), .req_ptag_i(req_ptag),
    .rsp_valid_o(rsp_valid), .rsp_hit_o(rsp_hit), .rsp_data_o(rsp_data),
    .mem_req_valid_o(mem_req_valid), .mem_req_ready_i(mem_req_ready),
    .mem_req_addr_o(mem_req_addr),
    .mem_rsp_valid_i(mem_rsp_valid), .mem_rsp_data_i(mem_rsp_data)
  );

  function automatic logic [31:0] mem_word(logic [31:0] line, int w);
    return (line | (32'(w) << 2)) ^ 32'hC3A5_0F01;
  endfunction

  function automatic logic [31:0] line_of(logic [19:0] ptag, int idx);
    return {ptag, 8'(idx), 4'b0000};
  endfunction

  task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // driver: push expectations, hold request until accepted, wait for the response
  task automatic rd(int idx, int word, logic [19:0] ptag, bit exp_hit, string req);
    bit acc;
    exp_data_q.push_back(mem_word(line_of(ptag, idx), word));
    exp_hit_q.push_back(exp_hit);
    exp_req_q.push_back(req);
    if (!exp_hit) exp_line_q.push_back(line_of(ptag, idx));
    req_valid = 1'b1;
    req_vaddr = {8'(idx), 2'(word)};
    req_ptag  = ptag;
    do begin
      @(negedge clk);
      acc = req_ready;
      @(posedge clk); #2;
    end while (!acc);
    req_valid = 1'b0;
    while (exp_data_q.size() != 0) @(negedge clk);
    @(posedge clk); #2;
  endtask

  // monitor: compare every response against the scoreboard head
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (exp_data_q.size() == 0) begin
        check(1'b0, "R3", "unexpected response", rsp_data, 32'h0);
      end else begin
        logic [31:0] ed;
        bit          eh;
        string       er;
        ed = exp_data_q.pop_front();
        eh = exp_hit_q.pop_front();
        er = exp_req_q.pop_front();
        check(rsp_data == ed, er, "response data", rsp_data, ed);
        check(rsp_hit == eh, er, "response hit flag", 32'(rsp_hit), 32'(eh));
      end
    end
  end

  // memory model: checks line requests, then supplies four ascending beats
  initial begin
    forever begin
      @(posedge clk); #2;
      mem_req_ready = 1'b0;
      if (rst_n && mem_req_valid) begin
        logic [31:0] line;
        logic [31:0] el;
        int lat, gap;
        line = mem_req_addr;
        lat  = req_lat;
        gap  = beat_gap;
        el   = (exp_line_q.size() != 0) ? exp_line_q.pop_front() : 32'hFFFF_FFFF;
        check(line == el, "R4", "line request address", line, el);
        check(req_ready == 1'b0, "R6", "ready low while requesting", 32'(req_ready), 32'd0);
        for (int c = 0; c < lat; c++) begin
          @(posedge clk); #2;
          check(mem_req_valid && mem_req_addr == line, "R4", "request held until ready",
                mem_req_addr, line);
        end
        mem_req_ready = 1'b1;
        @(posedge clk); #2;
        mem_req_ready = 1'b0;
        for (int b = 0; b < 4; b++) begin
          if (b > 0) begin
            for (int g = 0; g < gap; g++) begin
              mem_rsp_valid = 1'b0;
              @(posedge clk); #2;
            end
          end
          mem_rsp_valid = 1'b1;
          mem_rsp_data  = mem_word(line, b);
          check(req_ready == 1'b0, "R6", "ready low during refill", 32'(req_ready), 32'd0);
          @(posedge clk); #2;
        end
        mem_rsp_valid = 1'b0;
        check(req_ready == 1'b1, "R6", "ready back after last beat", 32'(req_ready), 32'd1);
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  localparam logic [19:0] TA = 20'hA0001, TB = 20'hB0002, TC = 20'hC0003,
                          TD = 20'hD0004, TE = 20'hE0005;

  initial begin
    repeat (3) @(posedge clk);
    #2;
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready == 1'b1, "R1", "ready after reset", 32'(req_ready), 32'd1);
    check(rsp_valid == 1'b0, "R1", "no response after reset", 32'(rsp_valid), 32'd0);
    check(mem_req_valid == 1'b0, "R1", "no line request after reset", 32'(mem_req_valid), 32'd0);
    @(posedge clk); #2;

    // R1/R4/R5: cold miss in set 5, word 2 forwarded mid-line
    rd(5, 2, TA, 1'b0, "R5");
    // R3/R7: other words of the refilled line hit
    rd(5, 0, TA, 1'b1, "R7");
    rd(5, 1, TA, 1'b1, "R3");
    rd(5, 3, TA, 1'b1, "R7");
    // R2: same set, other tag misses; R8: fills way 1, way 0 kept
    rd(5, 1, TB, 1'b0, "R2");
    rd(5, 0, TA, 1'b1, "R8");
    rd(5, 0, TC, 1'b0, "R8");
    rd(5, 3, TD, 1'b0, "R8");
    rd(5, 2, TB, 1'b1, "R8");
    rd(5, 2, TA, 1'b1, "R8");
    // recency now C,D,B,A (oldest first); R9: E replaces C
    rd(5, 2, TE, 1'b0, "R9");
    rd(5, 1, TD, 1'b1, "R9");
    rd(5, 0, TC, 1'b0, "R9");  // evicts B (order B,A,E,D)
    rd(5, 0, TA, 1'b1, "R9");
    rd(5, 1, TB, 1'b0, "R9");  // evicts E (order D,C,A,B)
    rd(5, 3, TD, 1'b1, "R9");
    rd(5, 3, TC, 1'b1, "R9");
    rd(5, 3, TE, 1'b0, "R9");  // evicts A
    rd(5, 0, TA, 1'b0, "R9");  // evicts B
    // R2: same tag in another set is a separate line; gaps and latency on refill
    req_lat = 3;
    beat_gap = 2;
    rd(6, 0, TA, 1'b0, "R2");
    rd(6, 3, TA, 1'b1, "R2");
    req_lat = 1;
    beat_gap = 1;
    rd(255, 3, 20'hFFFFF, 1'b0, "R5");
    rd(255, 3, 20'hFFFFF, 1'b1, "R7");
    rd(255, 0, 20'hFFFFF, 1'b1, "R7");
    req_lat = 0;
    beat_gap = 0;
    rd(0, 0, 20'h00000, 1'b0, "R5");
    rd(0, 2, 20'h00000, 1'b1, "R3");
    rd(255, 1, 20'hFFFFE, 1'b0, "R2");

    repeat (4) @(posedge clk);
    check(exp_data_q.size() == 0, "R5", "all expected responses seen",
          32'(exp_data_q.size()), 32'd0);
    check(exp_line_q.size() == 0, "R4", "all expected line requests seen",
          32'(exp_line_q.size()), 32'd0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule